// File: doc/BRIEF.md
# Bit-Level Serial EEPROM Responder

This block plays the target side of a two-wire serial memory that a bit-banging host drives one bus update at a time. On each cycle with `bus_upd` high it takes a fresh pair of clock and data line levels. It compares them with the pair from the previous update to find start conditions, stop conditions and rising clock edges. A single position counter steps through the transaction. First comes an eight-bit command, then an acknowledge slot. Then come eight bits that either set the word address (write command) or carry the current data byte out to the host (read command), and then a second acknowledge slot.

The responder only pulls the data line low. Its `sda_drv` output is 1 when released and 0 when driving acknowledge or a zero data bit. The host sees the wired-AND of its own level and `sda_drv`. The storage is a byte array that is filled through a separate synchronous load port, which is meant for testbenches and start-up images. The bus cannot write data bytes. A write command only moves the address pointer. The data register is loaded from the array at the last bit of the second phase, so a later read returns the byte at that address.

Top module: `i2c_eeprom_rsp`

## Requirements
- R1: After reset `sda_drv` is 1 and the responder is idle, waiting for a start.
- R2: While idle (no start seen since reset or since the last stop), clock pulses and data bits are ignored, and `sda_drv` stays 1.
- R3: After a start (data falls while clock stays high), the first eight accepted rising clock edges shift the data level into the command, and the first bit goes to the most significant position. On the ninth rising edge `sda_drv` is 0 (acknowledge).
- R4: When command bit 0 is 0 (write), the eight accepted rising edges after the first acknowledge shift the data level into the word address, first bit most significant. On the next rising edge `sda_drv` is 0 (second acknowledge). The same second acknowledge also follows a read.
- R5: When command bit 0 is 1 (read), `sda_drv` carries the data register, most significant bit first, on the eight rising edges after the first acknowledge. The data register holds the byte stored at the current word address, including bytes placed through the load port.
- R6: Reading again without a new write returns the same byte, because the data register is reloaded from the unchanged address at the end of each second phase.
- R7: A stop (data rises while clock stays high) returns the responder to idle from any point of a transaction, and `sda_drv` is released.
- R8: A start in the middle of a transaction restarts the command phase from its first bit.
- R9: A rising clock edge in the same update as a data change is not taken as a bit, and the counter does not advance.
- R10: After the second acknowledge, further rising edges leave `sda_drv` at 1 until the next start or stop.
- R11: Any update with the clock line low sets `sda_drv` to 1.
- R12: Cycles with `bus_upd` low change neither the line history nor the transaction state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_upd | input | 1 | New line levels present on this cycle |
| scl_lvl | input | 1 | Sampled clock line level |
| sda_lvl | input | 1 | Sampled data line level from the host |
| ld_en | input | 1 | Write one byte into the array |
| ld_addr | input | 8 | Array index for the load port |
| ld_data | input | 8 | Byte written by the load port |
| sda_drv | output | 1 | Responder data line drive, 0 pulls low, 1 releases |

## Verification
Assertions check the following on every cycle: the release while the clock is low, quiet idle, the two acknowledge slots, the return to idle on a stop, the held counter on a violating edge, the release after the second acknowledge, and freezing when there is no update. Only the bench scenarios can show the data path end to end. These cover the address bits landing in the right order, read bytes matching the array contents MSB first, repeated reads, and a bit that is rejected shifting the acknowledge by exactly one pulse. They also cover restart and abort sequences, and random addresses with contents refreshed through the load port.

// File: rtl/i2c_rsp_pkg.sv
package i2c_rsp_pkg;

    localparam int TICK_W = 5;

    // Transaction positions; order is behaviour
    localparam logic [TICK_W-1:0] T_IDLE     = 5'd0;
    localparam logic [TICK_W-1:0] T_CMD_LAST = 5'd8;
    localparam logic [TICK_W-1:0] T_CMD_FRST = 5'd1;
    localparam logic [TICK_W-1:0] T_ACK1     = 5'd9;
    localparam logic [TICK_W-1:0] T_PH2_LAST = 5'd17;
    localparam logic [TICK_W-1:0] T_ACK2     = 5'd18;
    localparam logic [TICK_W-1:0] T_DONE     = 5'd19;

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [7:0]        cmd;
        logic [7:0]        addr;
        logic [7:0]        data;
        logic              sda_drv;
    } rsp_state_t;

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_upd,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic scl_rise,
    output logic sda_chg,
    output logic cond_start,
    output logic cond_stop
);
    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (bus_upd) begin
            l_d.scl = scl_lvl;
            l_d.sda = sda_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            l_q <= l_d;
        end
    end

    assign scl_rise   = !l_q.scl && scl_lvl;
    assign sda_chg    = l_q.sda != sda_lvl;
    assign cond_start = l_q.scl && scl_lvl && l_q.sda && !sda_lvl;
    assign cond_stop  = l_q.scl && scl_lvl && !l_q.sda && sda_lvl;

    // R12: no update, history held
    p_hist_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_upd |=> $stable(l_q));

endmodule

// File: rtl/i2c_rsp_mem.sv
module i2c_rsp_mem #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_idx,
    input  logic [7:0]    ld_byte,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);
    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            cells_q[ld_idx] <= ld_byte;
        end
    end

    assign rd_byte = cells_q[rd_idx];

endmodule

// File: rtl/i2c_eeprom_rsp.sv
module i2c_eeprom_rsp
    import i2c_rsp_pkg::*;
#(
    parameter int MEM_DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_upd,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       ld_en,
    input  logic [7:0] ld_addr,
    input  logic [7:0] ld_data,
    output logic       sda_drv
);
    localparam int AW = $clog2(MEM_DEPTH);

    logic scl_rise, sda_chg, cond_start, cond_stop;
    logic [7:0] addr_shift;
    logic [7:0] rd_byte;
    logic [AW-1:0] rd_idx;
    rsp_state_t s_d, s_q;

    i2c_line_sense u_sense (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_upd    (bus_upd),
        .scl_lvl    (scl_lvl),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .sda_chg    (sda_chg),
        .cond_start (cond_start),
        .cond_stop  (cond_stop)
    );

    assign addr_shift = {s_q.addr[6:0], sda_lvl};
    assign rd_idx     = s_q.cmd[0] ? s_q.addr[AW-1:0] : addr_shift[AW-1:0];

    i2c_rsp_mem #(.DEPTH(MEM_DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .ld_en   (ld_en),
        .ld_idx  (ld_addr[AW-1:0]),
        .ld_byte (ld_data),
        .rd_idx  (rd_idx),
        .rd_byte (rd_byte)
    );

    always_comb begin
        s_d = s_q;
        if (bus_upd) begin
            if (cond_start) begin
                s_d.tick    = T_CMD_FRST;
                s_d.cmd     = '0;
                s_d.sda_drv = 1'b1;
            end else if (cond_stop) begin
                s_d.tick    = T_IDLE;
                s_d.sda_drv = 1'b1;
            end else if (s_q.tick == T_IDLE) begin
                s_d.sda_drv = 1'b1;
            end else if (scl_rise && sda_chg) begin
                s_d.sda_drv = 1'b1;
            end else if (scl_rise) begin
                if (s_q.tick <= T_CMD_LAST) begin
                    s_d.cmd     = {s_q.cmd[6:0], sda_lvl};
                    s_d.tick    = s_q.tick + 5'd1;
                    s_d.sda_drv = 1'b1;
                end else if (s_q.tick == T_ACK1) begin
                    s_d.sda_drv = 1'b0;
                    s_d.tick    = s_q.tick + 5'd1;
                end else if (s_q.tick <= T_PH2_LAST) begin
                    if (s_q.cmd[0]) begin
                        s_d.sda_drv = s_q.data[7];
                        s_d.data    = {s_q.data[6:0], 1'b0};
                    end else begin
                        s_d.addr    = addr_shift;
                        s_d.sda_drv = 1'b1;
                    end
                    if (s_q.tick == T_PH2_LAST) begin
                        s_d.data = rd_byte;
                    end
                    s_d.tick = s_q.tick + 5'd1;
                end else if (s_q.tick == T_ACK2) begin
                    s_d.sda_drv = 1'b0;
                    s_d.tick    = T_DONE;
                end else begin
                    s_d.sda_drv = 1'b1;
                end
            end else if (!scl_lvl) begin
                s_d.sda_drv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{tick: T_IDLE, cmd: 8'h00, addr: 8'h00, data: 8'h00, sda_drv: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_drv = s_q.sda_drv;

    // R2: idle never pulls the line
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.tick == T_IDLE) |-> sda_drv);

    // R3: first acknowledge slot
    p_cmd_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_upd && scl_rise && !sda_chg && s_q.tick == T_ACK1) |=> !sda_drv);

    // R4: second acknowledge slot
    p_ph2_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_upd && scl_rise && !sda_chg && s_q.tick == T_ACK2) |=> !sda_drv);

    // R7: stop returns to idle
    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_upd && cond_stop) |=> (s_q.tick == T_IDLE && sda_drv));

    // R9: violating edge does not advance
    p_viol_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_upd && scl_rise && sda_chg) |=> $stable(s_q.tick));

    // R10: released after the second acknowledge
    p_done_rel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_upd && scl_rise && !sda_chg && s_q.tick == T_DONE) |=> sda_drv);

    // R11: clock low releases
    p_low_rel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_upd && !scl_lvl) |=> sda_drv);

    // R12: no update, state frozen
    p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_upd |=> $stable(s_q));

    p_tick_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tick <= T_DONE);

endmodule

// File: tb/sim_i2c_eeprom_rsp.sv
module sim_i2c_eeprom_rsp;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_upd = 1'b0;
    logic       scl_lvl = 1'b1;
    logic       sda_lvl = 1'b1;
    logic       ld_en = 1'b0;
    logic [7:0] ld_addr = 8'h00;
    logic [7:0] ld_data = 8'h00;
    logic       sda_drv;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] model [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_eeprom_rsp u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_upd (bus_upd),
        .scl_lvl (scl_lvl),
        .sda_lvl (sda_lvl),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .sda_drv (sda_drv)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [7:0] seed_byte(input int a);
        return 8'((a * 73 + 29) ^ (a >> 3));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic c, input logic d, input logic u = 1'b1);
        @(negedge clk);
        scl_lvl = c;
        sda_lvl = d;
        bus_upd = u;
        @(negedge clk);
        bus_upd = 1'b0;
    endtask

    task automatic load(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        model[a] = v;
    endtask

    task automatic pulse(input logic b, output logic obs);
        bus(1'b0, b);
        bus(1'b1, b);
        obs = sda_drv;
        bus(1'b0, b);
    endtask

    task automatic do_start();
        bus(1'b0, 1'b1); bus(1'b1, 1'b1); bus(1'b1, 1'b0); bus(1'b0, 1'b0);
    endtask

    task automatic do_stop();
        bus(1'b0, 1'b0); bus(1'b1, 1'b0); bus(1'b1, 1'b1);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic [7:0] obs);
        for (int i = 7; i >= 0; i--) begin
            logic o;
            pulse(v[i], o);
            obs[i] = o;
        end
    endtask

    task automatic set_addr(input logic [7:0] a);
        logic o;
        logic [7:0] ob;
        do_start();
        send_byte(8'hA0, ob);
        pulse(1'b1, o);
        chk("R3 cmd ack", {7'd0, o}, 8'h00);
        send_byte(a, ob);
        pulse(1'b1, o);
        chk("R4 addr ack", {7'd0, o}, 8'h00);
        chk("R11 release low", {7'd0, sda_drv}, 8'h01);
        do_stop();
    endtask

    task automatic read_cur(output logic [7:0] got);
        logic o;
        logic [7:0] ob;
        do_start();
        send_byte(8'hA1, ob);
        pulse(1'b1, o);
        chk("R3 cmd ack rd", {7'd0, o}, 8'h00);
        send_byte(8'hFF, got);
        pulse(1'b1, o);
        chk("R4 ack after read", {7'd0, o}, 8'h00);
        do_stop();
    endtask

    initial begin
        logic o;
        logic [7:0] ob, got;
        void'($urandom(32'd20240611));
        for (int a = 0; a < 256; a++) model[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 256; a++) load(8'(a), seed_byte(a));

        // R1 reset state
        chk("R1 reset release", {7'd0, sda_drv}, 8'h01);

        // R2 idle ignores pulses
        for (int i = 0; i < 9; i++) pulse(1'b0, o);
        chk("R2 idle no ack", {7'd0, o}, 8'h01);

        // R5, R6 directed
        set_addr(8'h3C);
        read_cur(got);
        chk("R5 read 3C", got, model[8'h3C]);
        read_cur(got);
        chk("R6 repeat read", got, model[8'h3C]);
        set_addr(8'h00);
        read_cur(got);
        chk("R5 read 00", got, model[8'h00]);
        set_addr(8'hFF);
        read_cur(got);
        chk("R5 read FF", got, model[8'hFF]);

        // R5 random addresses, refreshed contents
        for (int n = 0; n < 24; n++) begin
            logic [7:0] a;
            a = 8'($urandom_range(0, 255));
            if (n % 3 == 0) load(a, 8'($urandom_range(0, 255)));
            set_addr(a);
            read_cur(got);
            chk("R5 random read", got, model[a]);
        end

        // R10 pulses after second ack are released
        do_start();
        send_byte(8'hA0, ob);
        pulse(1'b1, o);
        send_byte(8'h12, ob);
        pulse(1'b1, o);
        chk("R4 ack before done", {7'd0, o}, 8'h00);
        pulse(1'b0, o);
        chk("R10 released 1", {7'd0, o}, 8'h01);
        pulse(1'b0, o);
        chk("R10 released 2", {7'd0, o}, 8'h01);
        do_stop();
        read_cur(got);
        chk("R4 address from write", got, model[8'h12]);

        // R7 stop aborts
        do_start();
        for (int i = 0; i < 4; i++) pulse(1'b1, o);
        do_stop();
        for (int i = 0; i < 9; i++) pulse(1'b0, o);
        chk("R7 no ack after stop", {7'd0, o}, 8'h01);

        // R8 repeated start restarts command
        do_start();
        for (int i = 0; i < 3; i++) pulse(1'b0, o);
        do_start();
        send_byte(8'hA0, ob);
        chk("R8 no early ack", {7'd0, ob[0]}, 8'h01);
        pulse(1'b1, o);
        chk("R8 ack on ninth", {7'd0, o}, 8'h00);
        do_stop();

        // R9 violating edge not counted
        do_start();
        for (int i = 0; i < 3; i++) pulse(1'b1, o);
        bus(1'b0, 1'b0);
        bus(1'b1, 1'b1);
        bus(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) pulse(1'b0, o);
        chk("R9 last cmd bit no ack", {7'd0, o}, 8'h01);
        pulse(1'b1, o);
        chk("R9 ack shifted", {7'd0, o}, 8'h00);
        do_stop();

        // R12 updates gated
        bus(1'b0, 1'b1, 1'b0); bus(1'b1, 1'b1, 1'b0);
        bus(1'b1, 1'b0, 1'b0); bus(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 9; i++) begin
            bus(1'b1, 1'b0, 1'b0);
            bus(1'b0, 1'b0, 1'b0);
        end
        chk("R12 gated no ack", {7'd0, sda_drv}, 8'h01);
        for (int i = 0; i < 9; i++) pulse(1'b0, o);
        chk("R12 still idle", {7'd0, o}, 8'h01);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule